// File: doc/BRIEF.md
# Register Rename Unit with Sequence-Ordered Rollback

This block is the rename stage of an out-of-order core for one thread. Each cycle it accepts at most one instruction with two source operands and an optional destination. The sources are translated through a map table into physical register numbers, each with a ready bit from a scoreboard. A destination takes a fresh physical register from a free list. The old mapping is recorded in a history buffer, and the entries in that buffer are ordered by instruction sequence number.

Two sequence-number inputs keep the history buffer short and recover from mispredictions. A commit number retires every entry at or below it, which frees the physical registers those entries displaced. A squash number undoes every entry above it, which restores the map and returns the newly allocated registers. Both walks complete in a single cycle. The zero register and the misc registers are never renamed. A write to one of them still leaves a history entry, but that entry names the same register as both new and previous. The entry is recognised by that match and is never used to free a register or to rewrite the map.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural index i (integer 0..7, float 8..15, misc 16..19) maps to physical register i, every physical register is ready, and physical registers 20..31 are free. Rename is ready when no squash or commit is requested.
- R2: Each source reports the physical register currently mapped to it, together with that register's ready bit. Sources are read before the same instruction's destination updates the map, so an instruction that reads its own destination sees the older mapping.
- R3: An integer destination other than index 0, or a float destination, takes the lowest-numbered free physical register. The old register is reported as the previous mapping and the new register is marked not ready. A write-back marks its register ready again.
- R4: A destination of index 0 or of a misc index is not renamed. Its new and previous registers are both equal to the fixed register, the map is left unchanged, and the register stays ready.
- R5: A squash removes every history entry whose sequence number is greater than the squash number. For each removed entry it restores the previous mapping and returns the new register to the free list.
- R6: A commit removes every history entry whose sequence number is less than or equal to the commit number, and returns each removed entry's previous register to the free list.
- R7: A history entry whose new and previous registers are equal is removed by squash or commit without touching the map or the free list. Physical register 0 and the misc registers are never allocated.
- R8: A source index of 20 or above, or a destination index of 20 or above when a destination is present, raises the error output. In that case nothing is renamed and no history entry is written.
- R9: Rename is not ready while the free list is empty or while all 16 history entries are in use.
- R10: Squash takes priority over commit: when both are requested in the same cycle, the commit is ignored. While either is requested, rename is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is offered for rename |
| ren_seq | input | 8 | Sequence number of the offered instruction |
| src0_arch | input | 5 | First source architectural index |
| src1_arch | input | 5 | Second source architectural index |
| dst_valid | input | 1 | The instruction has a destination |
| dst_arch | input | 5 | Destination architectural index |
| ren_ready | output | 1 | Rename can accept this cycle |
| ren_err | output | 1 | An operand index is outside every class |
| src0_phys | output | 5 | Physical register for source 0 |
| src0_rdy | output | 1 | Ready bit of src0_phys |
| src1_phys | output | 5 | Physical register for source 1 |
| src1_rdy | output | 1 | Ready bit of src1_phys |
| dst_phys | output | 5 | Physical register assigned to the destination |
| dst_prev_phys | output | 5 | Physical register previously mapped to the destination |
| wb_valid | input | 1 | Write-back marks a register ready |
| wb_phys | input | 5 | Physical register written back |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | 8 | Commit sequence number (inclusive) |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 8 | Squash sequence number (entries above it removed) |

## Verification
The hardest case to reach is a history buffer that holds a mix of real renames and special-register entries, where a squash or commit then crosses both kinds. A leak caused by a skipped match shows up only later, as a wrong allocation choice. The bench therefore writes the zero register and a misc register between real renames, squashes or commits across them, and then checks which register the next allocation picks. Because allocation always takes the lowest free register, a wrongly freed register 0 or 17 would be picked ahead of the expected one. The two stall conditions are reached one at a time. Sixteen zero-register writes fill the history without using any free register, and after a full commit twelve real renames empty the free list.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_FP   = 2'd1,
        CLS_MISC = 2'd2,
        CLS_BAD  = 2'd3
    } rcls_e;
endpackage

// File: rtl/rn_class_dec.sv
module rn_class_dec #(
    parameter int AW     = 5,
    parameter int N_INT  = 8,
    parameter int N_FP   = 8,
    parameter int N_MISC = 4
) (
    input  logic [AW-1:0] idx,
    output rn_pkg::rcls_e cls
);
    localparam int FP_END   = N_INT + N_FP;
    localparam int MISC_END = FP_END + N_MISC;

    always_comb begin
        if (int'(idx) < N_INT)         cls = rn_pkg::CLS_INT;
        else if (int'(idx) < FP_END)   cls = rn_pkg::CLS_FP;
        else if (int'(idx) < MISC_END) cls = rn_pkg::CLS_MISC;
        else                           cls = rn_pkg::CLS_BAD;
    end
endmodule

// File: rtl/rn_pick_free.sv
module rn_pick_free #(
    parameter int NPHYS = 32,
    parameter int PW    = 5
) (
    input  logic [NPHYS-1:0] vec,
    output logic             found,
    output logic [PW-1:0]    idx
);
    // lowest set bit wins: scan from the top so lower indices overwrite
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NPHYS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = PW'(i);
            end
        end
    end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int AW     = 5,
    parameter int N_INT  = 8,
    parameter int N_FP   = 8,
    parameter int N_MISC = 4,
    parameter int NPHYS  = 32,
    parameter int HB     = 16,
    parameter int SEQW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ren_valid,
    input  logic [SEQW-1:0] ren_seq,
    input  logic [AW-1:0]   src0_arch,
    input  logic [AW-1:0]   src1_arch,
    input  logic            dst_valid,
    input  logic [AW-1:0]   dst_arch,
    output logic            ren_ready,
    output logic            ren_err,
    output logic [$clog2(NPHYS)-1:0] src0_phys,
    output logic            src0_rdy,
    output logic [$clog2(NPHYS)-1:0] src1_phys,
    output logic            src1_rdy,
    output logic [$clog2(NPHYS)-1:0] dst_phys,
    output logic [$clog2(NPHYS)-1:0] dst_prev_phys,
    input  logic            wb_valid,
    input  logic [$clog2(NPHYS)-1:0] wb_phys,
    input  logic            commit_valid,
    input  logic [SEQW-1:0] commit_seq,
    input  logic            squash_valid,
    input  logic [SEQW-1:0] squash_seq
);
    import rn_pkg::*;

    localparam int PW    = $clog2(NPHYS);
    localparam int HW    = $clog2(HB);
    localparam int NRN   = N_INT + N_FP;
    localparam int MW    = $clog2(NRN);
    localparam int NARCH = NRN + N_MISC;

    typedef struct packed {
        logic [SEQW-1:0] seq;
        logic [AW-1:0]   arch;
        logic [PW-1:0]   newp;
        logic [PW-1:0]   prevp;
    } hent_t;

    typedef struct packed {
        logic [NRN-1:0][PW-1:0] map;
        logic [NPHYS-1:0]       free;
        logic [NPHYS-1:0]       rdy;
        hent_t [HB-1:0]         hb;
        logic [HW-1:0]          head;
        logic [HW:0]            cnt;
    } state_t;

    state_t st_d, st_q;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NRN; i++) s.map[i] = PW'(i);
        for (int p = 0; p < NPHYS; p++) begin
            s.rdy[p]  = 1'b1;
            s.free[p] = (p >= NARCH);
        end
        return s;
    endfunction

    function automatic logic [PW-1:0] lookup(input logic [AW-1:0] a, input rcls_e c,
                                             input logic [NRN-1:0][PW-1:0] m);
        logic [PW-1:0] r;
        case (c)
            CLS_INT, CLS_FP: r = m[a[MW-1:0]];
            CLS_MISC:        r = PW'(a);
            default:         r = '0;
        endcase
        return r;
    endfunction

    // operand class decode: one decoder per operand
    logic  [2:0][AW-1:0] dec_idx;
    rcls_e               dec_cls [3];
    assign dec_idx = {dst_arch, src1_arch, src0_arch};

    for (genvar g = 0; g < 3; g++) begin : g_dec
        rn_class_dec #(.AW(AW), .N_INT(N_INT), .N_FP(N_FP), .N_MISC(N_MISC)) u_dec (
            .idx(dec_idx[g]),
            .cls(dec_cls[g])
        );
    end

    logic          free_found;
    logic [PW-1:0] free_idx;

    rn_pick_free #(.NPHYS(NPHYS), .PW(PW)) u_pick (
        .vec  (st_q.free),
        .found(free_found),
        .idx  (free_idx)
    );

    logic          dst_renamed;
    logic          fire;
    logic          keep;
    logic [HW:0]   n_rm;
    logic [HW-1:0] slot;
    hent_t         e;

    always_comb begin
        st_d = st_q;
        keep = 1'b1;
        n_rm = '0;
        slot = '0;
        e    = '0;

        // sources read the current map before any update this cycle
        src0_phys = lookup(src0_arch, dec_cls[0], st_q.map);
        src1_phys = lookup(src1_arch, dec_cls[1], st_q.map);
        src0_rdy  = st_q.rdy[src0_phys];
        src1_rdy  = st_q.rdy[src1_phys];

        ren_err = (dec_cls[0] == CLS_BAD) || (dec_cls[1] == CLS_BAD) ||
                  (dst_valid && (dec_cls[2] == CLS_BAD));
        dst_renamed = dst_valid &&
                      ((dec_cls[2] == CLS_FP) ||
                       ((dec_cls[2] == CLS_INT) && (dst_arch != '0)));
        dst_prev_phys = lookup(dst_arch, dec_cls[2], st_q.map);
        dst_phys      = dst_renamed ? free_idx : dst_prev_phys;

        ren_ready = !squash_valid && !commit_valid && free_found &&
                    (st_q.cnt != (HW+1)'(HB));
        fire = ren_valid && ren_ready && !ren_err;

        if (wb_valid) st_d.rdy[wb_phys] = 1'b1;

        if (squash_valid) begin
            // youngest to oldest; older restores overwrite younger ones
            for (int k = HB - 1; k >= 0; k--) begin
                if (k < int'(st_q.cnt)) begin
                    slot = st_q.head + HW'(k);
                    e    = st_q.hb[slot];
                    if (keep && (e.seq > squash_seq)) begin
                        n_rm = n_rm + 1'b1;
                        if (e.newp != e.prevp) begin
                            st_d.map[e.arch[MW-1:0]] = e.prevp;
                            st_d.free[e.newp]        = 1'b1;
                        end
                    end else begin
                        keep = 1'b0;
                    end
                end
            end
            st_d.cnt = st_q.cnt - n_rm;
        end else if (commit_valid) begin
            for (int k = 0; k < HB; k++) begin
                if (k < int'(st_q.cnt)) begin
                    slot = st_q.head + HW'(k);
                    e    = st_q.hb[slot];
                    if (keep && (e.seq <= commit_seq)) begin
                        n_rm = n_rm + 1'b1;
                        if (e.newp != e.prevp) st_d.free[e.prevp] = 1'b1;
                    end else begin
                        keep = 1'b0;
                    end
                end
            end
            st_d.head = st_q.head + n_rm[HW-1:0];
            st_d.cnt  = st_q.cnt - n_rm;
        end else if (fire && dst_valid) begin
            slot = st_q.head + st_q.cnt[HW-1:0];
            st_d.hb[slot] = '{seq: ren_seq, arch: dst_arch,
                              newp: dst_phys, prevp: dst_prev_phys};
            st_d.cnt = st_q.cnt + 1'b1;
            if (dst_renamed) begin
                st_d.map[dst_arch[MW-1:0]] = dst_phys;
                st_d.free[dst_phys]        = 1'b0;
                st_d.rdy[dst_phys]         = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
    parameter int NPHYS = 32,
    parameter int HB    = 16,
    parameter int AW    = 5,
    parameter int PW    = $clog2(NPHYS),
    parameter int HW    = $clog2(HB)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ren_valid,
    input logic             ren_ready,
    input logic             ren_err,
    input logic             dst_valid,
    input logic [PW-1:0]    dst_phys,
    input logic [PW-1:0]    dst_prev_phys,
    input logic [AW-1:0]    src0_arch,
    input logic [PW-1:0]    src0_phys,
    input logic             src0_rdy,
    input logic             wb_valid,
    input logic [PW-1:0]    wb_phys,
    input logic             squash_valid,
    input logic             commit_valid,
    input logic [HW:0]      cnt,
    input logic [NPHYS-1:0] free,
    input logic [NPHYS-1:0] rdy
);
    logic real_fire;
    assign real_fire = ren_valid && ren_ready && !ren_err && dst_valid &&
                       (dst_phys != dst_prev_phys);

    p_hist_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (HW+1)'(HB));

    p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == (HW+1)'(HB)) |-> !ren_ready);

    p_walk_blocks_ren_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid || commit_valid) |-> !ren_ready);

    p_alloc_from_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        real_fire |-> free[dst_phys]);

    p_alloc_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (real_fire && !(wb_valid && wb_phys == dst_phys)) |=> !rdy[$past(dst_phys)]);

    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src0_arch == '0) |-> (src0_phys == '0) && src0_rdy);

    p_zero_never_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !free[0]);

    p_err_no_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_err) |=> (cnt == $past(cnt)));
endmodule

bind rename_unit rn_checker #(.NPHYS(NPHYS), .HB(HB), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_ready    (ren_ready),
    .ren_err      (ren_err),
    .dst_valid    (dst_valid),
    .dst_phys     (dst_phys),
    .dst_prev_phys(dst_prev_phys),
    .src0_arch    (src0_arch),
    .src0_phys    (src0_phys),
    .src0_rdy     (src0_rdy),
    .wb_valid     (wb_valid),
    .wb_phys      (wb_phys),
    .squash_valid (squash_valid),
    .commit_valid (commit_valid),
    .cnt          (st_q.cnt),
    .free         (st_q.free),
    .rdy          (st_q.rdy)
);

// File: tb/tb_rename_unit.sv
`timescale 1ns/1ps
module tb_rename_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 0, dst_valid = 0, wb_valid = 0;
    logic       commit_valid = 0, squash_valid = 0;
    logic [7:0] ren_seq = 0, commit_seq = 0, squash_seq = 0;
    logic [4:0] src0_arch = 0, src1_arch = 0, dst_arch = 0, wb_phys = 0;
    logic       ren_ready, ren_err, src0_rdy, src1_rdy;
    logic [4:0] src0_phys, src1_phys, dst_phys, dst_prev_phys;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rename_unit dut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_seq(ren_seq),
        .src0_arch(src0_arch), .src1_arch(src1_arch), .dst_valid(dst_valid),
        .dst_arch(dst_arch), .ren_ready(ren_ready), .ren_err(ren_err),
        .src0_phys(src0_phys), .src0_rdy(src0_rdy), .src1_phys(src1_phys),
        .src1_rdy(src1_rdy), .dst_phys(dst_phys), .dst_prev_phys(dst_prev_phys),
        .wb_valid(wb_valid), .wb_phys(wb_phys), .commit_valid(commit_valid),
        .commit_seq(commit_seq), .squash_valid(squash_valid), .squash_seq(squash_seq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ren_valid = 0; dst_valid = 0; wb_valid = 0;
        commit_valid = 0; squash_valid = 0;
    endtask

    task automatic drive_ren(input int seq, input int s0, input int s1,
                             input bit dv, input int d);
        @(negedge clk);
        ren_valid = 1; ren_seq = 8'(seq);
        src0_arch = 5'(s0); src1_arch = 5'(s1);
        dst_valid = dv; dst_arch = 5'(d);
        #1;
    endtask

    task automatic look(input int a, input int exp_p, input int exp_r, input string tag);
        @(negedge clk);
        ren_valid = 0; src0_arch = 5'(a); src1_arch = 5'(a);
        #1;
        chk({tag, " src0 phys"}, src0_phys, exp_p);
        chk({tag, " src0 ready"}, src0_rdy, exp_r);
        chk({tag, " src1 phys"}, src1_phys, exp_p);
    endtask

    task automatic do_squash(input int s);
        @(negedge clk); squash_valid = 1; squash_seq = 8'(s); tick();
    endtask

    task automatic do_commit(input int c);
        @(negedge clk); commit_valid = 1; commit_seq = 8'(c); tick();
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 ready after reset", ren_ready, 1);
        look(3, 3, 1, "R1 int identity");
        look(12, 12, 1, "R1 fp identity");
        look(18, 18, 1, "R1 misc identity");
    endtask

    task automatic t_basic();
        drive_ren(10, 3, 9, 1, 3);
        chk("R2 src reads old map", src0_phys, 3);
        chk("R2 src ready", src0_rdy, 1);
        chk("R2 src1 phys", src1_phys, 9);
        chk("R3 alloc lowest free", dst_phys, 20);
        chk("R3 prev mapping", dst_prev_phys, 3);
        chk("R8 no error", ren_err, 0);
        tick();
        look(3, 20, 0, "R3 new map not ready");
        @(negedge clk); wb_valid = 1; wb_phys = 5'd20; tick();
        look(3, 20, 1, "R3 writeback ready");
    endtask

    task automatic t_special();
        drive_ren(11, 0, 0, 1, 0);
        chk("R4 zero dst new", dst_phys, 0);
        chk("R4 zero dst prev", dst_prev_phys, 0);
        tick();
        drive_ren(12, 0, 0, 1, 17);
        chk("R4 misc dst new", dst_phys, 17);
        chk("R4 misc dst prev", dst_prev_phys, 17);
        tick();
        look(0, 0, 1, "R4 zero unchanged");
        look(17, 17, 1, "R4 misc stays ready");
    endtask

    task automatic t_squash();
        drive_ren(13, 0, 0, 1, 9);
        chk("R3 fp alloc", dst_phys, 21);
        tick();
        do_squash(11);
        look(9, 9, 1, "R5 map restored");
        look(3, 20, 1, "R5 older entry kept");
        drive_ren(14, 0, 0, 1, 5);
        chk("R5/R7 squash freed 21 not 17", dst_phys, 21);
        tick();
    endtask

    task automatic t_commit();
        do_commit(11);
        drive_ren(15, 0, 0, 1, 6);
        chk("R6/R7 commit freed prev 3 not 0", dst_phys, 3);
        tick();
        look(5, 21, 0, "R6 live map kept");
    endtask

    task automatic t_err();
        drive_ren(16, 25, 0, 1, 7);
        chk("R8 bad source flagged", ren_err, 1);
        tick();
        drive_ren(16, 0, 0, 1, 30);
        chk("R8 bad dest flagged", ren_err, 1);
        tick();
        drive_ren(16, 0, 0, 0, 30);
        chk("R8 absent dest ignored", ren_err, 0);
        @(negedge clk); ren_valid = 0; #1;
        look(7, 7, 1, "R8 no rename on error");
        drive_ren(16, 0, 0, 1, 7);
        chk("R8 next alloc unaffected", dst_phys, 22);
        tick();
    endtask

    task automatic t_prio();
        @(negedge clk);
        squash_valid = 1; squash_seq = 8'd15;
        commit_valid = 1; commit_seq = 8'd200;
        ren_valid = 1; ren_seq = 8'd17; dst_valid = 1; dst_arch = 5'd1;
        #1;
        chk("R10 rename blocked during walk", ren_ready, 0);
        tick();
        look(7, 7, 1, "R10 squash applied");
        look(5, 21, 0, "R10 commit ignored map");
        drive_ren(17, 0, 0, 1, 1);
        chk("R10 commit ignored free list", dst_phys, 22);
        tick();
    endtask

    task automatic t_stall();
        do_commit(200);
        for (int i = 0; i < 16; i++) begin
            drive_ren(18 + i, 0, 0, 1, 0);
            if (!ren_ready) chk("R9 ready while history has room", ren_ready, 1);
            tick();
        end
        drive_ren(34, 0, 0, 1, 0);
        chk("R9 stall on full history", ren_ready, 0);
        tick();
        do_commit(200);
        for (int i = 0; i < 12; i++) begin
            drive_ren(40 + i, 0, 0, 1, 1 + (i % 7));
            if (!ren_ready) chk("R9 ready while regs free", ren_ready, 1);
            tick();
        end
        drive_ren(52, 0, 0, 1, 2);
        chk("R9 stall on empty free list", ren_ready, 0);
        tick();
        do_commit(200);
        @(negedge clk); #1;
        chk("R9 ready after release", ren_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_special();
        t_squash();
        t_commit();
        t_err();
        t_prio();
        t_stall();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule